// File: doc/BRIEF.md
# Chained Two-or-Three Cell Programmable Divider

This block divides a fast clock by any whole number in a contiguous range. The range is set by a small control word. It is built from a row of identical stages. Each stage passes on one of every two, or one of every three, of the input edges it sees. It then hands that slower edge stream to the stage after it. Once per output period a "last slot" marker starts at the far end of the chain and walks back toward the front. Each stage retimes the marker before handing it on. A stage whose control bit is set stretches its current period by one input edge while the marker from its neighbour is active. The marker leaving the front stage is the divider output: a pulse one clock wide per output period. With `NUM_CELLS` stages and control word `P`, the period is `2**NUM_CELLS + P` input clocks. The default of five stages gives 32 to 63.

All state runs on the input clock. Each stage advances only on the cycles in which the stage before it produces an edge. The control word is captured only at the clock edge that ends an output pulse. A value written while a period is running therefore reshapes the following period and never the current one. A synchronous reset puts every stage at the start of a period and loads the control word. Counting starts cleanly at the first edge after reset.

Top module: `mmd_divider`

## Requirements
- R1: `div_o` produces one pulse per output period, and consecutive rising edges are exactly `2**NUM_CELLS + P` clock cycles apart. `P` is the captured control word read as an unsigned number whose bit i weighs 2**i (32 + P for the default).
- R2: A stage stretches its period to three input edges only when its own control bit is 1 and the marker from the following stage is active; otherwise its period is two input edges.
- R3: The marker enters the chain at the last stage, whose marker input is held active. Each stage raises its own marker only while its input marker is active and holds it for one of its input periods. The front stage's marker is `div_o`, and the last stage finishes a period in exactly the cycles where `div_o` is high.
- R4: While `rst` is high, `div_o` is 0 and `ratio_i` is loaded. The first pulse after release appears after exactly `2**NUM_CELLS + P - 1` clock edges.
- R5: A change of `ratio_i` during a running period does not alter that period's length. The new value governs the period that starts after the next pulse.
- R6: `ratio_i` is sampled only at the clock edge on which `div_o` is high. Among several writes inside one period, only the value present at that edge takes effect, including a write made while the pulse is showing.
- R7: Every pulse on `div_o` is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; also loads the control word |
| ratio_i | input | NUM_CELLS | Control word P; period is 2**NUM_CELLS + P clocks |
| div_o | output | 1 | One-cycle pulse per output period |

## Verification
Every control word from 0 to 31 is applied through a reset. The first interval and two steady intervals are measured for each. Odd words isolate the front stage's stretch, and the all-ones and all-zeros words mark the ends of the range. A write halfway through a period separates correct boundary capture from immediate capture. A burst of three writes inside one period, followed by a write during the pulse itself, shows that only the value present at the capture edge counts. The front stage raises its marker within a single clock, so a marker that is mistimed at any stage moves the pulse, and the measured length catches it.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    // Position of a stage inside its current output period.
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2
    } phase_t;

    // Registered state of one stage.
    typedef struct packed {
        phase_t phase;
        logic   mark;
    } cell_state_t;

    function automatic phase_t phase_after(input phase_t ph);
        phase_t nx;
        case (ph)
            PH_0:    nx = PH_1;
            PH_1:    nx = PH_2;
            default: nx = PH_0;
        endcase
        return nx;
    endfunction

    // Total period in input clocks for a chain of the given length.
    function automatic int unsigned full_ratio(input int unsigned cells,
                                               input int unsigned ctrl);
        return (32'd1 << cells) + ctrl;
    endfunction

endpackage

// File: rtl/mmd_cell.sv
module mmd_cell
    import mmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,    // an input edge of this stage occurs this cycle
    input  logic mark_i,  // marker from the following stage
    input  logic ctrl_i,  // captured control bit of this stage
    output logic en_o,    // edge handed to the following stage
    output logic mark_o   // retimed marker toward the front
);

    cell_state_t st_q;
    cell_state_t st_d;
    phase_t      last_ph;
    logic        wrap;

    always_comb begin
        last_ph = (ctrl_i && mark_i) ? PH_2 : PH_1;
        wrap    = (st_q.phase == last_ph);
        en_o    = en_i && wrap;
        st_d    = st_q;
        if (en_i) begin
            if (wrap) begin
                st_d.phase = PH_0;
                st_d.mark  = 1'b0;
            end else begin
                st_d.phase = phase_after(st_q.phase);
                st_d.mark  = mark_i && (st_d.phase == last_ph);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_0;
            st_q.mark  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mark_o = st_q.mark;

    AST_STRETCH_GATED: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_2) |-> (ctrl_i && mark_i)); // R2

    AST_MARK_NEEDS_NEXT: assert property (@(posedge clk) disable iff (rst)
        mark_o |-> mark_i); // R3

    AST_MARK_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (mark_o && en_i) |=> !mark_o); // R3

endmodule

// File: rtl/mmd_ratio_latch.sv
module mmd_ratio_latch #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary_i,
    input  logic [WIDTH-1:0] ratio_i,
    output logic [WIDTH-1:0] ratio_o
);

    logic [WIDTH-1:0] ratio_q;

    always_ff @(posedge clk) begin
        if (rst || boundary_i) begin
            ratio_q <= ratio_i;
        end
    end

    assign ratio_o = ratio_q;

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary_i |=> $stable(ratio_o)); // R5

endmodule

// File: rtl/mmd_divider.sv
module mmd_divider
    import mmd_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CELLS-1:0] ratio_i,
    output logic                 div_o
);

    localparam int unsigned GAP_W = NUM_CELLS + 1;

    logic [NUM_CELLS-1:0] ratio_q;
    logic [NUM_CELLS:0]   chain_en;
    logic [NUM_CELLS:0]   chain_mark;

    assign chain_en[0]           = 1'b1;
    assign chain_mark[NUM_CELLS] = 1'b1;

    mmd_ratio_latch #(.WIDTH(NUM_CELLS)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (div_o),
        .ratio_i    (ratio_i),
        .ratio_o    (ratio_q)
    );

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        mmd_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .en_i   (chain_en[g]),
            .mark_i (chain_mark[g+1]),
            .ctrl_i (ratio_q[g]),
            .en_o   (chain_en[g+1]),
            .mark_o (chain_mark[g])
        );
    end

    assign div_o = chain_mark[0];

    // Clocks since the previous pulse, kept only for the period check.
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || div_o) begin
            gap_q <= GAP_W'(1);
        end else begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
        div_o |-> (gap_q == GAP_W'(full_ratio(NUM_CELLS, 32'(ratio_q))))); // R1

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        div_o |=> !div_o); // R7

    AST_TAIL_WRAP: assert property (@(posedge clk) disable iff (rst)
        chain_en[NUM_CELLS] == div_o); // R3

endmodule

// File: tb/mmd_divider_tb.sv
`timescale 1ns/1ps
module mmd_divider_tb;

    localparam int unsigned NUM_CELLS = 5;
    localparam int unsigned BASE      = 1 << NUM_CELLS;

    typedef struct {
        int unsigned len;
        string       tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NUM_CELLS-1:0] ratio_i = '0;
    logic                 div_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    mmd_divider #(.NUM_CELLS(NUM_CELLS)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .ratio_i (ratio_i),
        .div_o   (div_o)
    );

    // Monitor: measures spacing and width of pulses, scores against queue.
    int unsigned gap   = 0;
    int unsigned width = 0;
    logic        prev  = 1'b0;

    always begin
        @(posedge clk);
        #1;
        if (rst) begin
            gap   = 0;
            width = 0;
            prev  = 1'b0;
        end else begin
            gap++;
            if (div_o && !prev) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected pulse: actual=%0d expected=none", gap);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (gap != e.len) begin
                        fails++;
                        $display("FAIL %s period: actual=%0d expected=%0d", e.tag, gap, e.len);
                    end
                end
                gap = 0;
            end
            if (div_o) width++;
            if (!div_o && prev) begin
                checks++;
                if (width != 1) begin
                    fails++;
                    $display("FAIL R7 pulse width: actual=%0d expected=1", width);
                end
                width = 0;
            end
            prev = div_o;
        end
    end

    task automatic push_exp(input int unsigned len, input string tag);
        exp_t e;
        e.len = len;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input int unsigned p);
        @(negedge clk);
        ratio_i = NUM_CELLS'(p);
        rst     = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (div_o !== 1'b0) begin
            fails++;
            $display("FAIL R4 output in reset: actual=%b expected=0", div_o);
        end
        rst = 1'b0;
    endtask

    task automatic wait_drained();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        // Sweep of every control word (R1, R2, R3, R4)
        for (int p = 0; p < (1 << NUM_CELLS); p++) begin
            do_reset(p);
            push_exp(BASE + p - 1, "R4 first");
            push_exp(BASE + p, "R1 R2 R3");
            push_exp(BASE + p, "R1 R2 R3");
            wait_drained();
        end

        // Mid-period write affects only the following period (R5)
        do_reset(5);
        push_exp(BASE + 5 - 1, "R4 first");
        push_exp(BASE + 5, "R5 old kept");
        while (exp_q.size() > 1) @(negedge clk);
        repeat (5) @(negedge clk);
        ratio_i = NUM_CELLS'(20);
        push_exp(BASE + 20, "R5 new");
        push_exp(BASE + 20, "R5 new");
        wait_drained();

        // Several writes in one period: last one before the capture edge wins (R6)
        repeat (3) @(negedge clk);
        ratio_i = NUM_CELLS'(3);
        repeat (4) @(negedge clk);
        ratio_i = NUM_CELLS'(17);
        repeat (4) @(negedge clk);
        ratio_i = NUM_CELLS'(9);
        push_exp(BASE + 20, "R6 current");
        push_exp(BASE + 9, "R6 last write");
        push_exp(BASE + 9, "R6 last write");
        wait_drained();

        // Write while the pulse is showing: captured at that pulse's edge (R6)
        push_exp(BASE + 9, "R6 before");
        wait_drained();
        checks++;
        if (div_o !== 1'b1) begin
            fails++;
            $display("FAIL R6 pulse visible at write: actual=%b expected=1", div_o);
        end
        ratio_i = NUM_CELLS'(31);
        push_exp(BASE + 31, "R6 edge write");
        push_exp(BASE + 31, "R6 edge write");
        wait_drained();

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule